// File: doc/BRIEF.md
# Protected-Mode Exception Entry Sequencer

This controller carries out the hardware half of entering an interrupt or exception handler for a simple 32-bit processor model. The core hands it a vector number, whether the event is a trap or a fault, whether it came from a software interrupt instruction, and its current code selector, instruction pointers, flags, stack selector and stack pointer. The sequencer fetches the gate for that vector from a descriptor table in memory, located by a base address and a byte limit that software loads beforehand, and validates the gate. It then writes the return frame onto the handler's stack one 32-bit word at a time and presents the register state the handler starts with.

Privilege is taken from the low two bits of the code selector, with 0 meaning kernel. An event raised at a non-zero level moves onto the kernel stack held in a task-state register pair, and the old stack selector and pointer go onto that new stack first. An event raised at kernel level stays on the current stack and saves only the flags, code selector and return pointer. Vectors 0 to 31 are the processor's own exceptions. Higher vectors carry device and software interrupts. The sequencer handles every vector the same way.

The descriptor memory port has a read latency of one cycle. The stack write port accepts a word every cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is active, and after it is released until the first request, busy, done, err, rd_en and wr_en are all low.
- R2: An accepted request reads two 32-bit words. The first read is at table base + 8*vector and returns the handler offset. The second read, in the next cycle, is at that address + 4. Its bits 15:0 hold the code selector, bits 19:16 the gate type, bits 22:21 the gate privilege, bit 23 the present flag, and bits 20 and 31:24 are reserved.
- R3: A request is accepted only if 8*vector+7 does not exceed the loaded byte limit. Otherwise err pulses for one cycle right after the request edge, with no reads and no writes.
- R4: If the present flag is 0, or the gate type is neither 0xE (interrupt gate) nor 0xF (trap gate), or a reserved bit is set, err pulses and no stack write takes place.
- R5: A software request whose current privilege is numerically greater than the gate privilege raises err. A software request whose current privilege is not greater than the gate privilege proceeds.
- R6: At a non-zero current privilege, the frame goes on the stored kernel stack. Five words are written at ESP0-4, -8, -12, -16 and -20: old SS (zero-extended), old ESP, EFLAGS, CS (zero-extended) and the saved EIP. The new SS is SS0 and the new ESP is ESP0-20.
- R7: At privilege 0, three words are written at ESP-4, -8 and -12: EFLAGS, CS and the saved EIP. SS is kept and the new ESP is ESP-12.
- R8: The saved EIP is the next-instruction pointer for a trap and the current-instruction pointer for a fault.
- R9: The new EFLAGS has bits 8 (TF), 14 (NT), 16 (RF) and 17 (VM) cleared. Bit 9 (IF) is cleared for an interrupt gate and kept for a trap gate. All other bits are kept, and the frame holds the unmodified EFLAGS.
- R10: The new CS is the gate selector with bits 1:0 forced to 0, and the new EIP is the handler offset.
- R11: busy is high from the accepting edge until done. Requests seen while busy are ignored. done pulses for one cycle, 3+N cycles after the accepting edge, where N is the number of words written. Table and stack loads apply to later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_ld | input | 1 | Load descriptor table base and limit |
| tbl_base_i | input | 32 | Descriptor table base byte address |
| tbl_limit_i | input | 16 | Descriptor table byte limit |
| stk_ld | input | 1 | Load kernel stack pair |
| stk_ss0_i | input | 16 | Kernel stack selector |
| stk_esp0_i | input | 32 | Kernel stack pointer |
| req_i | input | 1 | Event request |
| req_vec_i | input | 8 | Vector number |
| req_trap_i | input | 1 | 1 = trap, 0 = fault |
| req_soft_i | input | 1 | Raised by a software interrupt instruction |
| cur_cs_i | input | 16 | Current code selector |
| cur_eip_i | input | 32 | Pointer to the causing instruction |
| nxt_eip_i | input | 32 | Pointer past the causing instruction |
| cur_eflags_i | input | 32 | Current flags |
| cur_ss_i | input | 16 | Current stack selector |
| cur_esp_i | input | 32 | Current stack pointer |
| rd_en_o | output | 1 | Descriptor read strobe |
| rd_addr_o | output | 32 | Descriptor read byte address |
| rd_data_i | input | 32 | Descriptor read data, one cycle after strobe |
| wr_en_o | output | 1 | Stack write strobe |
| wr_addr_o | output | 32 | Stack write byte address |
| wr_data_o | output | 32 | Stack write data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Frame complete, new state valid |
| err_o | output | 1 | Request rejected |
| new_cs_o | output | 16 | Handler code selector |
| new_eip_o | output | 32 | Handler entry pointer |
| new_eflags_o | output | 32 | Handler flags |
| new_ss_o | output | 16 | Handler stack selector |
| new_esp_o | output | 32 | Handler stack pointer |

## Verification
A wrong push index or a wrong starting stack pointer shows up in the first stack write: either the address differs from ESP0-4 or ESP-4, or the data word belongs to another slot. The scoreboard therefore catches it on the first write strobe, before done. A corrupted descriptor capture, or a wrong gate-type decode, shows up only when done rises, as a wrong handler pointer or a wrong IF bit in the new flags. The same applies to a latency error, which the bench sees as done arriving in the wrong cycle. A lost busy state either lets a second request rewrite the stack, which appears as unexpected writes within a few cycles, or leaves err or done silent until the bench gives up waiting after 40 cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int FL_TF = 8;
  localparam int FL_IF = 9;
  localparam int FL_NT = 14;
  localparam int FL_RF = 16;
  localparam int FL_VM = 17;
  localparam logic [31:0] EFL_CLR  = (32'd1 << FL_TF) | (32'd1 << FL_NT) |
                                     (32'd1 << FL_RF) | (32'd1 << FL_VM);
  localparam logic [31:0] EFL_IFM  = 32'd1 << FL_IF;
  localparam logic [3:0]  GATE_INT = 4'hE;
  localparam logic [3:0]  GATE_TRP = 4'hF;
  localparam logic [2:0]  SLOT_SS  = 3'd0;
  localparam logic [2:0]  SLOT_FL  = 3'd2;
  localparam logic [2:0]  SLOT_IP  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_CHECK,
    ST_PUSH
  } seq_state_e;
endpackage

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs #(
  parameter int AW    = 32,
  parameter int VEC_W = 8,
  parameter int LIM_W = 16,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_ld,
  input  logic [AW-1:0]    base_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             stk_ld,
  input  logic [SEL_W-1:0] ss0_i,
  input  logic [AW-1:0]    esp0_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [SEL_W-1:0] ss0_o,
  output logic [AW-1:0]    esp0_o,
  output logic [AW-1:0]    ent_addr_o,
  output logic             in_range_o
);
  localparam int ENT_W = VEC_W + 3;
  localparam int CMP_W = (ENT_W > LIM_W) ? ENT_W : LIM_W;

  logic [AW-1:0]    base_q;
  logic [LIM_W-1:0] limit_q;
  logic [SEL_W-1:0] ss0_q;
  logic [AW-1:0]    esp0_q;
  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (tbl_ld) begin
      base_q  <= base_i;
      limit_q <= limit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss0_q  <= '0;
      esp0_q <= '0;
    end else if (stk_ld) begin
      ss0_q  <= ss0_i;
      esp0_q <= esp0_i;
    end
  end

  assign last_byte  = CMP_W'({vec_i, 3'b111});
  assign lim_ext    = CMP_W'(limit_q);
  assign in_range_o = (last_byte <= lim_ext);
  assign ent_addr_o = base_q + AW'({vec_i, 3'b000});
  assign ss0_o      = ss0_q;
  assign esp0_o     = esp0_q;
endmodule

// File: rtl/exc_gate_check.sv
module exc_gate_check
  import exc_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic [31:0]      desc_hi_i,
  input  logic [1:0]       cpl_i,
  input  logic             soft_i,
  output logic             ok_o,
  output logic             trap_o,
  output logic [SEL_W-1:0] sel_o
);
  logic       present;
  logic [1:0] dpl;
  logic [3:0] gtype;
  logic       rsvd_clr;
  logic       type_ok;
  logic       priv_ok;

  assign present  = desc_hi_i[23];
  assign dpl      = desc_hi_i[22:21];
  assign gtype    = desc_hi_i[19:16];
  assign rsvd_clr = (desc_hi_i[31:24] == 8'h00) && !desc_hi_i[20];
  assign type_ok  = (gtype == GATE_INT) || (gtype == GATE_TRP);
  assign priv_ok  = !soft_i || (cpl_i <= dpl);
  assign ok_o     = present && type_ok && rsvd_clr && priv_ok;
  assign trap_o   = (gtype == GATE_TRP);
  assign sel_o    = SEL_W'(desc_hi_i[15:0]);
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             in_range_i,
  input  logic [AW-1:0]    ent_addr_i,
  input  logic             trap_i,
  input  logic             soft_i,
  input  logic [SEL_W-1:0] cs_i,
  input  logic [31:0]      eip_i,
  input  logic [31:0]      nxt_i,
  input  logic [31:0]      efl_i,
  input  logic [SEL_W-1:0] ss_i,
  input  logic [AW-1:0]    esp_i,
  input  logic [SEL_W-1:0] ss0_i,
  input  logic [AW-1:0]    esp0_i,
  input  logic             gate_ok_i,
  input  logic             gate_trap_i,
  input  logic [SEL_W-1:0] gate_sel_i,
  output logic [1:0]       cpl_o,
  output logic             soft_o,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [31:0]      rd_data_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [31:0]      wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [SEL_W-1:0] new_cs_o,
  output logic [31:0]      new_eip_o,
  output logic [31:0]      new_efl_o,
  output logic [SEL_W-1:0] new_ss_o,
  output logic [AW-1:0]    new_esp_o
);
  localparam logic [AW-1:0] WORD_B = AW'(4);

  seq_state_e       state_q, state_nx;
  logic             cap_en, chk_en, fin_en;
  logic [AW-1:0]    desc_addr_q;
  logic             soft_q;
  logic [SEL_W-1:0] cs_q, ss_q;
  logic [31:0]      seip_q, efl_q, off_q, off_nx;
  logic [AW-1:0]    esp_q;
  logic [AW-1:0]    sp_q, sp_nx;
  logic [2:0]       idx_q, idx_nx;
  logic [SEL_W-1:0] ncs_q, nss_q, ncs_nx, nss_nx;
  logic             gtrap_q;
  logic             done_q, done_nx, err_q, err_nx;
  logic [SEL_W-1:0] new_cs_q, new_ss_q;
  logic [31:0]      new_eip_q, new_efl_q, new_efl_nx;
  logic [AW-1:0]    new_esp_q;
  logic             to_kernel;

  assign to_kernel = (cs_q[1:0] != 2'b00);
  assign new_efl_nx = efl_q & ~EFL_CLR & (gtrap_q ? 32'hFFFF_FFFF : ~EFL_IFM);

  always_comb begin
    state_nx  = state_q;
    cap_en    = 1'b0;
    chk_en    = 1'b0;
    fin_en    = 1'b0;
    off_nx    = off_q;
    sp_nx     = sp_q;
    idx_nx    = idx_q;
    ncs_nx    = ncs_q;
    nss_nx    = nss_q;
    done_nx   = 1'b0;
    err_nx    = 1'b0;
    rd_en_o   = 1'b0;
    rd_addr_o = desc_addr_q;
    wr_en_o   = 1'b0;
    wr_addr_o = sp_q - WORD_B;
    case (idx_q)
      3'd0:    wr_data_o = 32'(ss_q);
      3'd1:    wr_data_o = 32'(esp_q);
      3'd2:    wr_data_o = efl_q;
      3'd3:    wr_data_o = 32'(cs_q);
      default: wr_data_o = seip_q;
    endcase
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (in_range_i) begin
            cap_en   = 1'b1;
            state_nx = ST_RD_LO;
          end else begin
            err_nx = 1'b1;
          end
        end
      end
      ST_RD_LO: begin
        rd_en_o  = 1'b1;
        state_nx = ST_RD_HI;
      end
      ST_RD_HI: begin
        rd_en_o   = 1'b1;
        rd_addr_o = desc_addr_q + WORD_B;
        off_nx    = rd_data_i;
        state_nx  = ST_CHECK;
      end
      ST_CHECK: begin
        if (!gate_ok_i) begin
          err_nx   = 1'b1;
          state_nx = ST_IDLE;
        end else begin
          chk_en   = 1'b1;
          sp_nx    = to_kernel ? esp0_i : esp_q;
          nss_nx   = to_kernel ? ss0_i : ss_q;
          idx_nx   = to_kernel ? SLOT_SS : SLOT_FL;
          ncs_nx   = {gate_sel_i[SEL_W-1:2], 2'b00};
          state_nx = ST_PUSH;
        end
      end
      ST_PUSH: begin
        wr_en_o = 1'b1;
        sp_nx   = sp_q - WORD_B;
        idx_nx  = idx_q + 3'd1;
        if (idx_q == SLOT_IP) begin
          fin_en   = 1'b1;
          done_nx  = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      off_q   <= '0;
      sp_q    <= '0;
      idx_q   <= '0;
      ncs_q   <= '0;
      nss_q   <= '0;
    end else begin
      state_q <= state_nx;
      done_q  <= done_nx;
      err_q   <= err_nx;
      off_q   <= off_nx;
      sp_q    <= sp_nx;
      idx_q   <= idx_nx;
      ncs_q   <= ncs_nx;
      nss_q   <= nss_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_addr_q <= '0;
      soft_q      <= 1'b0;
      cs_q        <= '0;
      ss_q        <= '0;
      seip_q      <= '0;
      efl_q       <= '0;
      esp_q       <= '0;
    end else if (cap_en) begin
      desc_addr_q <= ent_addr_i;
      soft_q      <= soft_i;
      cs_q        <= cs_i;
      ss_q        <= ss_i;
      seip_q      <= trap_i ? nxt_i : eip_i;
      efl_q       <= efl_i;
      esp_q       <= esp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gtrap_q <= 1'b0;
    end else if (chk_en) begin
      gtrap_q <= gate_trap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_cs_q  <= '0;
      new_ss_q  <= '0;
      new_eip_q <= '0;
      new_efl_q <= '0;
      new_esp_q <= '0;
    end else if (fin_en) begin
      new_cs_q  <= ncs_q;
      new_ss_q  <= nss_q;
      new_eip_q <= off_q;
      new_efl_q <= new_efl_nx;
      new_esp_q <= sp_nx;
    end
  end

  assign cpl_o     = cs_q[1:0];
  assign soft_o    = soft_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign new_cs_o  = new_cs_q;
  assign new_ss_o  = new_ss_q;
  assign new_eip_o = new_eip_q;
  assign new_efl_o = new_efl_q;
  assign new_esp_o = new_esp_q;

  AST_RD_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_HI) |-> (rd_addr_o == $past(rd_addr_o) + WORD_B)); // R2
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_q && done_q)); // R3
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) - WORD_B)); // R6
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((new_efl_q & EFL_CLR) == 32'd0)); // R9
  AST_CS_RING0: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (new_cs_q[1:0] == 2'b00)); // R10
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(seip_q) && $stable(cs_q))); // R11
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int AW    = 32,
  parameter int VEC_W = 8,
  parameter int LIM_W = 16,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_ld,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic [LIM_W-1:0] tbl_limit_i,
  input  logic             stk_ld,
  input  logic [SEL_W-1:0] stk_ss0_i,
  input  logic [AW-1:0]    stk_esp0_i,
  input  logic             req_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             req_trap_i,
  input  logic             req_soft_i,
  input  logic [SEL_W-1:0] cur_cs_i,
  input  logic [31:0]      cur_eip_i,
  input  logic [31:0]      nxt_eip_i,
  input  logic [31:0]      cur_eflags_i,
  input  logic [SEL_W-1:0] cur_ss_i,
  input  logic [AW-1:0]    cur_esp_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [31:0]      rd_data_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [31:0]      wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [SEL_W-1:0] new_cs_o,
  output logic [31:0]      new_eip_o,
  output logic [31:0]      new_eflags_o,
  output logic [SEL_W-1:0] new_ss_o,
  output logic [AW-1:0]    new_esp_o
);
  logic [1:0]       rs_q;
  logic             rst_ns;
  logic [SEL_W-1:0] ss0_w;
  logic [AW-1:0]    esp0_w;
  logic [AW-1:0]    ent_addr_w;
  logic             in_range_w;
  logic [1:0]       cpl_w;
  logic             soft_w;
  logic             gate_ok_w;
  logic             gate_trap_w;
  logic [SEL_W-1:0] gate_sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  exc_ctx_regs #(.AW(AW), .VEC_W(VEC_W), .LIM_W(LIM_W), .SEL_W(SEL_W)) ctx_i (
    .clk        (clk),
    .rst_n      (rst_ns),
    .tbl_ld     (tbl_ld),
    .base_i     (tbl_base_i),
    .limit_i    (tbl_limit_i),
    .stk_ld     (stk_ld),
    .ss0_i      (stk_ss0_i),
    .esp0_i     (stk_esp0_i),
    .vec_i      (req_vec_i),
    .ss0_o      (ss0_w),
    .esp0_o     (esp0_w),
    .ent_addr_o (ent_addr_w),
    .in_range_o (in_range_w)
  );

  exc_gate_check #(.SEL_W(SEL_W)) gate_i (
    .desc_hi_i (rd_data_i),
    .cpl_i     (cpl_w),
    .soft_i    (soft_w),
    .ok_o      (gate_ok_w),
    .trap_o    (gate_trap_w),
    .sel_o     (gate_sel_w)
  );

  exc_seq_fsm #(.AW(AW), .SEL_W(SEL_W)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_ns),
    .req_i       (req_i),
    .in_range_i  (in_range_w),
    .ent_addr_i  (ent_addr_w),
    .trap_i      (req_trap_i),
    .soft_i      (req_soft_i),
    .cs_i        (cur_cs_i),
    .eip_i       (cur_eip_i),
    .nxt_i       (nxt_eip_i),
    .efl_i       (cur_eflags_i),
    .ss_i        (cur_ss_i),
    .esp_i       (cur_esp_i),
    .ss0_i       (ss0_w),
    .esp0_i      (esp0_w),
    .gate_ok_i   (gate_ok_w),
    .gate_trap_i (gate_trap_w),
    .gate_sel_i  (gate_sel_w),
    .cpl_o       (cpl_w),
    .soft_o      (soft_w),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .rd_data_i   (rd_data_i),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .new_cs_o    (new_cs_o),
    .new_eip_o   (new_eip_o),
    .new_efl_o   (new_eflags_o),
    .new_ss_o    (new_ss_o),
    .new_esp_o   (new_esp_o)
  );
endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_ld, stk_ld, req, r_trap, r_soft;
  logic [31:0] tbl_base, stk_esp0, r_eip, r_nxt, r_efl, r_esp;
  logic [15:0] tbl_limit, stk_ss0, r_cs, r_ss;
  logic [7:0]  r_vec;
  logic        rd_en, wr_en, busy, done, err;
  logic [31:0] rd_addr, wr_addr, wr_data, n_eip, n_efl, n_esp;
  logic [31:0] rd_data;
  logic [15:0] n_cs, n_ss;

  logic [31:0] mem [logic [31:0]];
  logic [63:0] exp_q [$];

  int total = 0, bad = 0;
  int mon_total = 0, mon_bad = 0;

  logic [31:0] m_base, m_esp0;
  logic [15:0] m_limit, m_ss0;
  logic [31:0] d_off;
  logic [15:0] d_sel;
  logic [3:0]  d_type;
  logic [1:0]  d_dpl;
  logic        d_p;
  logic [7:0]  d_rsvd;
  int          inject_at;

  always #2 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .tbl_ld(tbl_ld), .tbl_base_i(tbl_base), .tbl_limit_i(tbl_limit),
    .stk_ld(stk_ld), .stk_ss0_i(stk_ss0), .stk_esp0_i(stk_esp0),
    .req_i(req), .req_vec_i(r_vec), .req_trap_i(r_trap), .req_soft_i(r_soft),
    .cur_cs_i(r_cs), .cur_eip_i(r_eip), .nxt_eip_i(r_nxt), .cur_eflags_i(r_efl),
    .cur_ss_i(r_ss), .cur_esp_i(r_esp),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .err_o(err),
    .new_cs_o(n_cs), .new_eip_o(n_eip), .new_eflags_o(n_efl),
    .new_ss_o(n_ss), .new_esp_o(n_esp)
  );

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem.exists(rd_addr) ? mem[rd_addr] : 32'hDEAD_BEEF;
  end

  // monitor: every stack write must match the head of the scoreboard (R6, R7)
  always @(negedge clk) begin
    if (wr_en) begin
      mon_total++;
      if (exp_q.size() == 0) begin
        mon_bad++;
        $display("FAIL R7 unexpected write: act=%h:%h exp=none", wr_addr, wr_data);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          mon_bad++;
          $display("FAIL R6 stack write: act=%h:%h exp=%h:%h", wr_addr, wr_data, e[63:32], e[31:0]);
        end
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic load_tbl(input logic [31:0] b, input logic [15:0] l);
    @(negedge clk); tbl_base = b; tbl_limit = l; tbl_ld = 1'b1;
    @(negedge clk); tbl_ld = 1'b0;
    m_base = b; m_limit = l;
  endtask

  task automatic load_stk(input logic [15:0] s, input logic [31:0] p);
    @(negedge clk); stk_ss0 = s; stk_esp0 = p; stk_ld = 1'b1;
    @(negedge clk); stk_ld = 1'b0;
    m_ss0 = s; m_esp0 = p;
  endtask

  // driver: installs the gate, predicts the frame, issues the request, checks the result
  task automatic run_req(input string tag);
    logic [31:0] hi, sp, seip, efl_n, dadr;
    logic [15:0] nss;
    logic        e, sw, in_lim, typ_ok;
    int          nw, cyc;
    logic [7:0]  v0;
    hi   = {d_rsvd, d_p, d_dpl, 1'b0, d_type, d_sel};
    dadr = m_base + {21'd0, r_vec, 3'd0};
    mem[dadr]     = d_off;
    mem[dadr + 4] = hi;
    in_lim = ({8'd0, r_vec, 3'b111} <= {3'd0, m_limit});
    typ_ok = (d_type == 4'hE) || (d_type == 4'hF);
    e  = !in_lim || !d_p || !typ_ok || (d_rsvd != 0) || (r_soft && (r_cs[1:0] > d_dpl));
    sw = (r_cs[1:0] != 2'b00);
    nw = 0;
    sp = sw ? m_esp0 : r_esp;
    nss = sw ? m_ss0 : r_ss;
    seip = r_trap ? r_nxt : r_eip;
    efl_n = r_efl & ~32'h0003_4100;
    if (d_type == 4'hE) efl_n = efl_n & ~32'h0000_0200;
    if (!e) begin
      if (sw) begin
        sp = sp - 4; exp_q.push_back({sp, 16'd0, r_ss});
        sp = sp - 4; exp_q.push_back({sp, r_esp});
        nw = 2;
      end
      sp = sp - 4; exp_q.push_back({sp, r_efl});
      sp = sp - 4; exp_q.push_back({sp, 16'd0, r_cs});
      sp = sp - 4; exp_q.push_back({sp, seip});
      nw = nw + 3;
    end
    v0 = r_vec;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    cyc = 0;
    while (!done && !err && cyc < 40) begin
      if (cyc == inject_at) begin req = 1'b1; r_vec = v0 + 8'd1; r_cs = 16'h0008; r_esp = 32'h0000_3000; end
      else req = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req = 1'b0;
    r_vec = v0;
    chk("R3", {tag, " err"}, {31'd0, err}, {31'd0, e});
    if (e) begin
      chk("R11", {tag, " err latency"}, cyc, in_lim ? 3 : 0);
    end else begin
      chk("R11", {tag, " done latency"}, cyc, 3 + nw);
      chk("R10", {tag, " new cs"}, {16'd0, n_cs}, {16'd0, d_sel[15:2], 2'b00});
      chk("R10", {tag, " new eip"}, n_eip, d_off);
      chk("R9", {tag, " new eflags"}, n_efl, efl_n);
      chk(sw ? "R6" : "R7", {tag, " new ss"}, {16'd0, n_ss}, {16'd0, nss});
      chk(sw ? "R6" : "R7", {tag, " new esp"}, n_esp, sp);
    end
    @(negedge clk);
    chk("R11", {tag, " done pulse"}, {30'd0, done, busy}, 32'd0);
    @(negedge clk); @(negedge clk);
    chk("R4", {tag, " writes drained"}, exp_q.size(), 0);
    inject_at = -1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired: act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_ld = 1'b0; stk_ld = 1'b0; req = 1'b0;
    tbl_base = '0; tbl_limit = '0; stk_ss0 = '0; stk_esp0 = '0;
    r_vec = '0; r_trap = 1'b0; r_soft = 1'b0; r_cs = '0; r_eip = '0; r_nxt = '0;
    r_efl = '0; r_ss = '0; r_esp = '0; rd_data = '0; inject_at = -1;
    d_rsvd = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1", "in reset", {27'd0, busy, done, err, rd_en, wr_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "after reset", {27'd0, busy, done, err, rd_en, wr_en}, 32'd0);

    load_tbl(32'h0000_1000, 16'h03FF);
    load_stk(16'h0010, 32'h0000_8000);

    // R7 R8 kernel-level fault through an interrupt gate
    r_vec = 8'h21; r_trap = 1'b0; r_soft = 1'b0; r_cs = 16'h0008;
    r_eip = 32'h0010_0040; r_nxt = 32'h0010_0043; r_efl = 32'h0003_4303;
    r_ss = 16'h0010; r_esp = 32'h0000_6000;
    d_off = 32'h0020_1000; d_sel = 16'h000B; d_type = 4'hE; d_dpl = 2'd0; d_p = 1'b1;
    run_req("R7 kernel fault int-gate");

    // R6 R8 R5 user-level software trap through a trap gate with DPL 3
    r_vec = 8'h03; r_trap = 1'b1; r_soft = 1'b1; r_cs = 16'h001B;
    r_eip = 32'h0804_8000; r_nxt = 32'h0804_8001; r_efl = 32'h0002_0202;
    r_ss = 16'h0023; r_esp = 32'h0BFF_F000;
    d_off = 32'h0020_2000; d_sel = 16'h0008; d_type = 4'hF; d_dpl = 2'd3;
    run_req("R6 user trap trap-gate");

    // R6 R8 user-level fault through an interrupt gate
    r_vec = 8'h0E; r_trap = 1'b0; r_soft = 1'b0;
    d_off = 32'h0020_3000; d_type = 4'hE; d_dpl = 2'd0;
    run_req("R8 user fault int-gate");

    // R5 software request from user level to a DPL 0 gate
    r_vec = 8'h30; r_soft = 1'b1; d_dpl = 2'd0; d_type = 4'hF;
    run_req("R5 soft priv reject");
    r_soft = 1'b0;

    // R4 gate not present, bad type, reserved bit set
    r_vec = 8'h31; d_p = 1'b0; d_dpl = 2'd3;
    run_req("R4 not present");
    d_p = 1'b1; d_type = 4'h6;
    run_req("R4 bad type");
    d_type = 4'hE; d_rsvd = 8'h01;
    run_req("R4 reserved bits");
    d_rsvd = 8'h00;

    // R3 limit boundary: exactly covering 0x21 is accepted, 0x22 is not
    load_tbl(32'h0000_1000, 16'h010F);
    r_vec = 8'h21; r_cs = 16'h0008; r_esp = 32'h0000_6000; r_ss = 16'h0010;
    d_off = 32'h0020_4000;
    run_req("R3 at limit");
    r_vec = 8'h22;
    run_req("R3 past limit");

    // R11 request arriving while busy is ignored
    r_vec = 8'h20; inject_at = 2; d_off = 32'h0020_5000;
    run_req("R11 ignore while busy");

    // R2 R11 relocated table and new kernel stack apply to the next request
    load_tbl(32'h0004_0000, 16'h07FF);
    load_stk(16'h0030, 32'h0009_0000);
    r_vec = 8'h80; r_cs = 16'h0013; r_trap = 1'b1; r_nxt = 32'h0000_1234;
    r_efl = 32'h0000_4002; r_ss = 16'h001B; r_esp = 32'h0000_A000;
    d_off = 32'h0030_0000; d_sel = 16'h0018; d_type = 4'hF;
    run_req("R2 relocated table");

    summary();
    $finish;
  end
endmodule